// File: doc/BRIEF.md
# Read-Sequence Command Decoder

This block sits beside an asynchronous SRAM port whose accesses have already been sampled into a clock domain. It watches the stream of completed accesses and picks out commands hidden in ordinary reads. A command is six reads in a row. The first five addresses are fixed and shared by every command. The sixth address selects one of four commands: nonvolatile store, nonvolatile recall, automatic-store disable, or automatic-store enable. The reads themselves still go to the memory as normal. This block only recognises the pattern.

Each access arrives as a one-cycle strobe carrying an address and a write flag. Only address bits 14 down to 2 take part in matching. A write, or a read whose address does not fit, ends a partial sequence without issuing a command. When a sequence completes, the block raises a one-cycle command pulse with a 2-bit code. A busy lockout then follows for a parameterised number of clock cycles, and the matcher ignores every access during that time.

Top module: `seqcmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` and `busy` are low and the matcher is idle, so the next accepted read is treated as a first step.
- R2: Five accepted reads to 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by an accepted read to a command address, raise `cmd_valid` for exactly one cycle. That cycle is the one after the clock edge that sampled the sixth read. `cmd_code` then gives the command: 0x8FC0 gives 0 (store), 0x4C63 gives 1 (recall), 0x8B45 gives 2 (automatic-store disable), and 0x4B46 gives 3 (automatic-store enable).
- R3: Only address bits [14:2] are compared. Bits [1:0] and bits above 14 have no effect on matching.
- R4: An accepted write at any step resets the matcher to idle, and no command is issued for that sequence.
- R5: An accepted read that does not match the expected leading address aborts the sequence. That same read is then checked against the first leading address and, if it matches, counts as step one of a new sequence.
- R6: An accepted sixth read whose address is none of the four command addresses issues no command. It is handled like the aborting read in R5.
- R7: `busy` is high for exactly LOCK_CYCLES cycles, starting with the cycle in which `cmd_valid` is high. Accesses presented while `busy` is high are ignored: they neither advance nor abort a sequence.
- R8: Cycles without an access strobe between steps leave the sequence position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle strobe marking one completed access |
| acc_write | input | 1 | High when the access is a write |
| acc_addr | input | ADDR_W | Address of the access |
| cmd_valid | output | 1 | One-cycle pulse when a command is recognised |
| cmd_code | output | 2 | Code of the command (0 store, 1 recall, 2 auto-store off, 3 auto-store on) |
| busy | output | 1 | Lockout active; accesses are ignored |

## Verification
The bench builds the block with ADDR_W = 17 and LOCK_CYCLES = 24. The short lockout lets many complete commands, and accesses aimed at the busy window, fit in one run. The 17-bit address leaves two don't-care bits above bit 14 and two below bit 2, and the bench randomises all four so that masking is exercised on both sides of the compared field. Random stimulus is biased toward the expected next address, so long partial sequences, writes and mismatches at every step, and restarts on the first address occur often.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int LEAD_N = 5;
    localparam int FIN_N  = 4;
    localparam int KEY_HI = 14;
    localparam int KEY_LO = 2;
    localparam int KEY_W  = KEY_HI - KEY_LO + 1;
    localparam int STEP_W = $clog2(LEAD_N + 1);

    typedef enum logic [1:0] {
        CMD_STORE  = 2'd0,
        CMD_RECALL = 2'd1,
        CMD_AS_OFF = 2'd2,
        CMD_AS_ON  = 2'd3
    } cmd_e;

    // Leading addresses, in the order they must be read.
    function automatic logic [15:0] lead_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Sixth address for each command code.
    function automatic logic [15:0] final_addr(input int idx);
        case (idx)
            0:       return 16'h8FC0;
            1:       return 16'h4C63;
            2:       return 16'h8B45;
            default: return 16'h4B46;
        endcase
    endfunction

endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LEAD_N-1:0] lead_hit,
    output logic [FIN_N-1:0]  fin_hit
);

    logic [KEY_W-1:0] key;
    assign key = addr[KEY_HI:KEY_LO];

    for (genvar i = 0; i < LEAD_N; i++) begin : g_lead
        localparam logic [15:0] PAT = lead_addr(i);
        assign lead_hit[i] = (key == PAT[KEY_HI:KEY_LO]);
    end

    for (genvar j = 0; j < FIN_N; j++) begin : g_fin
        localparam logic [15:0] PAT = final_addr(j);
        assign fin_hit[j] = (key == PAT[KEY_HI:KEY_LO]);
    end

endmodule

// File: rtl/seqcmd_lockout.sv
module seqcmd_lockout #(
    parameter int LOCK_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (start) begin
            lock_d.cnt = CNT_W'(LOCK_CYCLES);
        end else if (lock_q.cnt != '0) begin
            lock_d.cnt = lock_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign busy = (lock_q.cnt != '0);

endmodule

// File: rtl/seqcmd_decoder.sv
module seqcmd_decoder
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int LOCK_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_code,
    output logic              busy
);

    localparam logic [STEP_W-1:0] LAST_LEAD = STEP_W'(LEAD_N);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              fire;
        cmd_e              code;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LEAD_N-1:0] lead_hit;
    logic [FIN_N-1:0]  fin_hit;
    logic [7:0]        lead_pad;
    logic              accept;
    logic [STEP_W-1:0] step_w;

    seqcmd_match #(.ADDR_W(ADDR_W)) i_match (
        .addr     (acc_addr),
        .lead_hit (lead_hit),
        .fin_hit  (fin_hit)
    );

    seqcmd_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_d.fire),
        .busy  (busy)
    );

    assign lead_pad = 8'(lead_hit);
    assign accept   = acc_valid && !busy;

    always_comb begin
        seq_d      = seq_q;
        seq_d.fire = 1'b0;
        if (accept) begin
            if (acc_write) begin
                seq_d.step = '0;
            end else if (seq_q.step < LAST_LEAD) begin
                if (lead_pad[seq_q.step]) begin
                    seq_d.step = seq_q.step + 1'b1;
                end else begin
                    seq_d.step = lead_hit[0] ? STEP_W'(1) : '0;
                end
            end else if (|fin_hit) begin
                seq_d.fire = 1'b1;
                seq_d.step = '0;
                for (int i = 0; i < FIN_N; i++) begin
                    if (fin_hit[i]) begin
                        seq_d.code = cmd_e'(2'(i));
                    end
                end
            end else begin
                seq_d.step = lead_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{step: '0, fire: 1'b0, code: CMD_STORE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step_w    = seq_q.step;
    assign cmd_valid = seq_q.fire;
    assign cmd_code  = seq_q.code;

endmodule

// File: rtl/seqcmd_checker.sv
module seqcmd_checker
    import seqcmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              cmd_valid,
    input logic              busy,
    input logic [STEP_W-1:0] step
);

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_cmd_after_last_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(step) == STEP_W'(LEAD_N)));

    p_write_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !busy) |=> (step == '0 && !cmd_valid));

    p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step <= STEP_W'(LEAD_N));

    p_busy_with_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    p_no_cmd_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cmd_valid);

    p_ignored_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step == '0));

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !cmd_valid) |=> $stable(step));

endmodule

bind seqcmd_decoder seqcmd_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .step      (step_w)
);

// File: tb/test_seqcmd_decoder.sv
`timescale 1ns/1ps
module test_seqcmd_decoder;

    localparam int ADDR_W = 17;
    localparam int LOCK   = 24;

    localparam logic [15:0] LEADS [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    localparam logic [15:0] FINS  [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_code;
    logic              busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int       m_step = 0;
    int       m_lock = 0;
    bit       e_fire;
    bit [1:0] e_code;

    always #5 clk = ~clk;

    seqcmd_decoder #(.ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK)) i_seqcmd_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .busy      (busy)
    );

    function automatic bit key_eq(logic [ADDR_W-1:0] a, logic [15:0] b);
        return a[14:2] == b[14:2];
    endfunction

    // Address with the compared field from base and random don't-care bits.
    function automatic logic [ADDR_W-1:0] noisy(logic [15:0] base);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'($urandom);
        a[14:2] = base[14:2];
        return a;
    endfunction

    task automatic check(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic tick(bit v, bit w, logic [ADDR_W-1:0] a, string tag);
        int k;
        @(negedge clk);
        acc_valid = v;
        acc_write = w;
        acc_addr  = a;
        e_fire = 1'b0;
        if (v && m_lock == 0) begin
            if (w) begin
                m_step = 0;
            end else if (m_step < 5) begin
                if (key_eq(a, LEADS[m_step])) m_step++;
                else m_step = key_eq(a, LEADS[0]) ? 1 : 0;
            end else begin
                k = -1;
                for (int i = 0; i < 4; i++) if (key_eq(a, FINS[i])) k = i;
                if (k >= 0) begin
                    e_fire = 1'b1;
                    e_code = 2'(k);
                    m_step = 0;
                end else begin
                    m_step = key_eq(a, LEADS[0]) ? 1 : 0;
                end
            end
        end
        if (e_fire) m_lock = LOCK;
        else if (m_lock > 0) m_lock--;
        @(posedge clk);
        #2;
        check(cmd_valid == e_fire, tag, "cmd_valid", int'(cmd_valid), int'(e_fire));
        if (e_fire) check(cmd_code == e_code, tag, "cmd_code", int'(cmd_code), int'(e_code));
        check(busy == (m_lock != 0), tag, "busy", int'(busy), int'(m_lock != 0));
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, '0, tag);
    endtask

    task automatic leads(int n, string tag);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, noisy(LEADS[i]), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1: reset state
        check(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);

        // R2 and R3: each command, don't-care bits randomised
        for (int k = 0; k < 4; k++) begin
            leads(5, "R2");
            tick(1'b1, 1'b0, noisy(FINS[k]), "R2_R3");
            idle(LOCK + 2, "R7");
        end

        // R8: idle gaps between steps
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 1'b0, noisy(LEADS[i]), "R8");
            idle(3, "R8");
        end
        tick(1'b1, 1'b0, noisy(FINS[0]), "R8");
        idle(LOCK + 1, "R7");

        // R4: write inside the sequence aborts it
        leads(3, "R4");
        tick(1'b1, 1'b1, noisy(LEADS[3]), "R4");
        tick(1'b1, 1'b0, noisy(LEADS[3]), "R4");
        tick(1'b1, 1'b0, noisy(LEADS[4]), "R4");
        tick(1'b1, 1'b0, noisy(FINS[1]), "R4");
        idle(2, "R4");

        // R5: aborting read equal to first address restarts the sequence
        leads(3, "R5");
        tick(1'b1, 1'b0, noisy(LEADS[0]), "R5");
        for (int i = 1; i < 5; i++) tick(1'b1, 1'b0, noisy(LEADS[i]), "R5");
        tick(1'b1, 1'b0, noisy(FINS[1]), "R5");
        idle(LOCK + 1, "R7");

        // R6: unknown sixth address
        leads(5, "R6");
        tick(1'b1, 1'b0, 17'h01234, "R6");
        tick(1'b1, 1'b0, noisy(FINS[2]), "R6");
        leads(5, "R6");
        tick(1'b1, 1'b0, noisy(LEADS[0]), "R6");
        for (int i = 1; i < 5; i++) tick(1'b1, 1'b0, noisy(LEADS[i]), "R6");
        tick(1'b1, 1'b0, noisy(FINS[3]), "R6");

        // R7: full sequence presented during the lockout is ignored
        leads(5, "R7");
        tick(1'b1, 1'b0, noisy(FINS[2]), "R7");
        idle(LOCK + 2, "R7");

        // Random mix biased toward the expected next address
        for (int n = 0; n < 4000; n++) begin
            r = int'($urandom % 100);
            if (r < 10)      tick(1'b0, 1'b0, '0, "rand_R8");
            else if (r < 15) tick(1'b1, 1'b1, noisy(LEADS[$urandom % 5]), "rand_R4");
            else if (r < 72) tick(1'b1, 1'b0, noisy(LEADS[(m_step < 5) ? m_step : 0]), "rand_R5");
            else if (r < 88) tick(1'b1, 1'b0, noisy(FINS[$urandom % 4]), "rand_R2");
            else             tick(1'b1, 1'b0, ADDR_W'($urandom), "rand_R6");
        end
        idle(LOCK + 2, "R7");
        finish_run();
    end

endmodule